// File: doc/BRIEF.md
# Serial Bit-Unstuffing Stage

This stage sits in the receive path of a full-speed USB serial link, after line decoding. It accepts one decoded data bit for each cycle in which its input qualifier is high. It counts how many ones have arrived in a row. Once that run reaches the stuffing length, it discards the bit that follows, because the transmitter inserted that bit only to keep the line transitioning.

In the cycle where a bit is discarded, the stage raises a stall flag, so that the next layer does not take a bit. If the discarded position holds a one and not the zero the transmitter should have inserted, the stage also raises an error flag. On an idle bus this error comes up again and again, which is expected. After each error the run count starts again from zero, so the stage keeps working when a packet begins. The stage runs in the 12 MHz bit-rate clock domain and has a synchronous reset.

Top module: `bit_unstuffer`

## Requirements
- R1: While reset is held, and in the cycle after it, `out_valid`, `out_bit`, `out_stall` and `out_err` are all 0.
- R2: A qualified input bit that is not in the stuffed position appears on `out_bit` one clock later, with `out_valid`=1, `out_stall`=0 and `out_err`=0.
- R3: After `RUN_LEN` (default 6) consecutive qualified ones, the next qualified bit is dropped. One clock later `out_valid`=1, `out_stall`=1 and `out_bit`=0.
- R4: If the dropped bit is a one, `out_err`=1 in the same output cycle as the stall. `out_err` is never 1 without `out_stall`.
- R5: Cycles with `in_valid`=0 leave the run count unchanged. One clock after such a cycle, `out_valid`, `out_stall` and `out_err` are 0.
- R6: A qualified zero bit, whether it is data or stuffed, clears the run count to zero.
- R7: After a stuffing error, the run count restarts from zero. On an unbroken stream of ones, the error therefore repeats on every (`RUN_LEN`+1)th bit.
- R8: Reset clears the run count. Ones received before the reset do not count towards the next stuffed bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifier for `in_bit` |
| in_bit | input | 1 | Decoded serial data bit |
| out_valid | output | 1 | One-cycle-delayed copy of `in_valid` |
| out_bit | output | 1 | Data bit passed downstream, 0 when stalled |
| out_stall | output | 1 | The qualified bit was a stuffed bit and was dropped |
| out_err | output | 1 | The stuffed position held a one |

## Verification
Each result is due exactly one clock after the qualified input that causes it, because every output goes through a single register. The bench drives inputs on the falling edge. Its reference model uses a plain integer run count and computes the expected outputs for that input, then compares them with the port values at the next falling edge. That edge is half a cycle after the rising edge that registers the result. The stimulus puts gaps without valid in the middle of runs, places reset in the middle of a run, and sends long unbroken streams of ones, so the checks fall on the stuffed positions that each requirement names.

// File: rtl/bit_unstuffer.sv
module bit_unstuffer #(
  parameter int RUN_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic in_bit,
  output logic out_valid,
  output logic out_bit,
  output logic out_stall,
  output logic out_err
);

  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q;
  logic          at_limit;

  assign at_limit = (run_q == CW'(RUN_LEN));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= '0;
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      out_stall <= 1'b0;
      out_err   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_stall <= at_limit;
        out_err   <= at_limit & in_bit;
        out_bit   <= in_bit & ~at_limit;
        if (at_limit || !in_bit) run_q <= '0;
        else                     run_q <= run_q + 1'b1;
      end else begin
        out_stall <= 1'b0;
        out_err   <= 1'b0;
      end
    end
  end

endmodule

module bit_unstuffer_chk (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic out_valid,
  input logic out_bit,
  input logic out_stall,
  input logic out_err
);

  // R4
  err_needs_stall_chk: assert property (@(posedge clk) disable iff (rst)
    out_err |-> out_stall);

  // R3
  stall_zero_bit_chk: assert property (@(posedge clk) disable iff (rst)
    out_stall |-> (out_valid && !out_bit));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_stall && !out_err));

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R2
  valid_delivered_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid)) |-> out_valid);

  // R6
  no_double_stall_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_stall) |=> !out_stall);

endmodule

bind bit_unstuffer bit_unstuffer_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_bit(out_bit), .out_stall(out_stall), .out_err(out_err)
);

// File: tb/bit_unstuffer_test.sv
module bit_unstuffer_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic out_valid, out_bit, out_stall, out_err;

  int total = 0;
  int bad = 0;
  int run = 0;
  logic e_valid = 0, e_bit = 0, e_stall = 0, e_err = 0;

  always #4 clk = ~clk;

  bit_unstuffer #(.RUN_LEN(6)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bit(in_bit),
    .out_valid(out_valid), .out_bit(out_bit),
    .out_stall(out_stall), .out_err(out_err)
  );

  task automatic compare(input string tag);
    total++;
    if ({out_valid, out_bit, out_stall, out_err} !== {e_valid, e_bit, e_stall, e_err}) begin
      bad++;
      $display("FAIL %s: got v=%b b=%b s=%b e=%b expected v=%b b=%b s=%b e=%b",
               tag, out_valid, out_bit, out_stall, out_err,
               e_valid, e_bit, e_stall, e_err);
    end
  endtask

  task automatic step(input logic v, input logic b, input string tag);
    in_valid = v;
    in_bit   = b;
    e_valid  = v;
    if (v) begin
      if (run == 6) begin
        e_stall = 1; e_err = b; e_bit = 0; run = 0;
      end else begin
        e_stall = 0; e_err = 0; e_bit = b;
        run = b ? run + 1 : 0;
      end
    end else begin
      e_stall = 0; e_err = 0;
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic do_reset(input string tag);
    rst = 1; in_valid = 0;
    run = 0; e_valid = 0; e_bit = 0; e_stall = 0; e_err = 0;
    @(negedge clk);
    compare(tag);
    @(negedge clk);
    compare(tag);
    rst = 0;
  endtask

  task automatic ones(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 1, tag);
  endtask

  initial begin
    #(200000 * 8);
    bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset("R1");
    step(0, 0, "R1");
    // R2 mixed data
    step(1, 1, "R2"); step(1, 0, "R2"); step(1, 1, "R2"); step(1, 0, "R2");
    step(1, 0, "R2"); step(1, 1, "R2"); step(1, 1, "R2"); step(1, 0, "R2");
    // R3 stuffed zero dropped
    ones(6, "R3"); step(1, 0, "R3"); step(1, 1, "R3"); step(1, 0, "R3");
    // R4 stuffing error
    ones(6, "R4"); step(1, 1, "R4"); step(1, 0, "R4");
    // R5 gaps do not advance the run
    ones(3, "R5"); step(0, 1, "R5"); step(0, 1, "R5");
    ones(3, "R5"); step(0, 0, "R5"); step(1, 0, "R5");
    // R6 zero clears the run
    ones(5, "R6"); step(1, 0, "R6"); ones(6, "R6"); step(1, 0, "R6");
    ones(6, "R6"); step(1, 0, "R6"); ones(5, "R6"); step(1, 1, "R6");
    step(1, 0, "R6");
    // R7 idle ones: repeated errors, restart from zero
    ones(22, "R7"); step(1, 0, "R7");
    ones(6, "R7"); step(1, 0, "R7");
    // R8 reset mid-run
    ones(5, "R8");
    do_reset("R8");
    ones(5, "R8"); step(1, 1, "R8"); step(1, 1, "R8");
    do_reset("R8");
    ones(4, "R8"); step(1, 0, "R8");
    step(0, 0, "R5");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule